// File: doc/BRIEF.md
# Automatic Sleep Detector for a Flash Read Path

This block decides when a flash-style memory drops into its low-power sleep state and freezes its output data register. It works in two ways, chosen by a mode input. In asynchronous mode it watches the address bus: an address that stays unchanged long enough puts the device to sleep, and any new address wakes it again at once. In synchronous mode it watches the burst clock. It sleeps when the first active burst-clock edge after a burst start comes later than the access time, or when the burst clock runs slower than the minimum frequency. In this mode only a fresh burst start wakes it.

All timing runs on a free-running reference clock. The access time, the extra stability margin and the minimum burst frequency are parameters in ns and kHz, and elaboration turns them into cycle counts. Chip-enable, write-enable and output-enable are not inputs, because the decision does not depend on them. While asleep, the data output keeps the last value it captured. An enclosing read path uses the latch-enable output to freeze its own data stage.

With the default parameters the counts are: a reference period of 8 ns, an access time of 80 ns and a 60 ns margin, so the stability threshold is ceil(140/8) = 18 cycles. The late-edge limit is ceil(80/8) = 10 cycles. The slow-clock limit is ceil(200/8) = 25 cycles, since 5 MHz is a 200 ns period.

Top module: `autosleep_det`

## Requirements
- R1: After reset, `sleep`, `latch_en` and `dout` are all 0.
- R2: In asynchronous mode, take edge k as the first reference edge that samples a new address. With the address held, `sleep` rises at edge k+STAB+1, where STAB = ceil((ACC_NS+MARGIN_NS)*1000/REF_PS). It is still 0 after edge k+STAB.
- R3: In asynchronous mode, a changed address clears `sleep` at the first reference edge that samples it and restarts the stability count from zero, so a second change before the threshold delays entry by the full STAB+1 edges again.
- R4: While `sleep` is 1, `latch_en` is 1 and `dout` keeps the value of `din` captured at the edge where sleep was entered. Changes on `din` have no effect until the block wakes. `dout` follows `din` again from the first edge after wake-up.
- R5: In synchronous mode (`sync_mode`=1), take edge s as the edge that samples `burst_start`=1. A rising `bclk` first sampled at edge s+k sets `sleep` at that edge when k-1 >= LATE = ceil(ACC_NS*1000/REF_PS). With k-1 = LATE-1, the block stays awake.
- R6: In synchronous mode, after the first burst-clock edge, if no further rising `bclk` is sampled within SLOW = ceil(1e9/(MIN_FREQ_KHZ*REF_PS)) reference edges, `sleep` rises at the SLOW-th edge. A next rising edge sampled exactly SLOW edges later keeps the block awake.
- R7: In synchronous mode, only `burst_start` clears `sleep`, at the edge that samples it. Address changes do not wake the block.
- R8: In asynchronous mode, `burst_start` and `bclk` have no effect on `sleep`.
- R9: A change of `sync_mode` clears `sleep` at the first edge that samples the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_mode | input | 1 | 1 = synchronous burst mode, 0 = asynchronous mode |
| addr | input | AW | Address bus watched in asynchronous mode |
| bclk | input | 1 | Burst clock level, sampled on `clk` |
| burst_start | input | 1 | One-cycle strobe marking the start of a burst |
| din | input | DW | Data from the array into the output register |
| sleep | output | 1 | 1 while the device is in automatic sleep |
| latch_en | output | 1 | 1 while the output data register is frozen |
| dout | output | DW | Output data register |

## Verification
A stability counter that restarts late or saturates early moves the rising edge of `sleep` by one or more reference cycles, so the bench samples `sleep` on both sides of each threshold edge. A burst watcher that is still armed or still disarmed when it should not be shows up as a wrong `sleep` value at the first or the next burst-clock edge. A state register that misses a wake-up condition leaves `dout` frozen after `din` moves, which becomes visible one edge after the wake event.

// File: rtl/asd_pkg.sv
package asd_pkg;

   typedef enum logic {
      ST_AWAKE = 1'b0,
      ST_SLEEP = 1'b1
   } sleep_st_t;

   function automatic int ceil_div(input longint num, input longint den);
      return int'((num + den - 1) / den);
   endfunction

endpackage

// File: rtl/asd_addr_watch.sv
module asd_addr_watch #(
   parameter int AW  = 16,
   parameter int THR = 18
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   output logic          chg,
   output logic          stable
);
   localparam int CW = $clog2(THR + 1);

   logic [AW-1:0] addr_q;
   logic [CW-1:0] run_cnt;

   assign chg    = (addr != addr_q);
   assign stable = (run_cnt == CW'(THR));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         run_cnt <= '0;
      end else begin
         addr_q <= addr;
         if (chg)
            run_cnt <= '0;
         else if (!stable)
            run_cnt <= run_cnt + 1'b1;
      end
   end

   // R3: any address change restarts the count
   p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      chg |=> (run_cnt == '0));

   // R2: once reached, the threshold holds while the address is unchanged
   p_saturate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (stable && !chg) |=> stable);

endmodule

// File: rtl/asd_bclk_watch.sv
module asd_bclk_watch #(
   parameter int LATE      = 10,
   parameter int SLOW      = 25,
   parameter bit EDGE_RISE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic bclk,
   input  logic burst_start,
   output logic late,
   output logic slow
);
   localparam int CMAX = (LATE > SLOW) ? LATE : SLOW;
   localparam int CW   = $clog2(CMAX + 1);

   logic          bclk_q;
   logic          act;
   logic          armed;
   logic          run;
   logic [CW-1:0] gap_cnt;

   generate
      if (EDGE_RISE) begin : g_rise
         assign act = bclk & ~bclk_q;
      end else begin : g_fall
         assign act = ~bclk & bclk_q;
      end
   endgenerate

   assign late = en && armed && act && (gap_cnt >= CW'(LATE));
   assign slow = en && run && !armed && !act && (gap_cnt == CW'(SLOW - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bclk_q  <= 1'b0;
         armed   <= 1'b0;
         run     <= 1'b0;
         gap_cnt <= '0;
      end else begin
         bclk_q <= bclk;
         if (!en) begin
            armed   <= 1'b0;
            run     <= 1'b0;
            gap_cnt <= '0;
         end else if (burst_start) begin
            armed   <= 1'b1;
            run     <= 1'b1;
            gap_cnt <= '0;
         end else if (run) begin
            if (act) begin
               armed   <= 1'b0;
               gap_cnt <= '0;
            end else if (gap_cnt != CW'(CMAX)) begin
               gap_cnt <= gap_cnt + 1'b1;
            end
         end
      end
   end

   // R6: a slow clock is reported once per gap
   p_slow_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
      slow |=> !slow);

   // R5: only the first edge after a burst start can be late
   p_late_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (late && !burst_start) |=> !late);

endmodule

// File: rtl/asd_sleep_fsm.sv
module asd_sleep_fsm
   import asd_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sync_mode,
   input  logic          chg,
   input  logic          stable,
   input  logic          late,
   input  logic          slow,
   input  logic          burst_start,
   input  logic [DW-1:0] din,
   output logic          sleep,
   output logic [DW-1:0] dout
);
   sleep_st_t st, st_nx;
   logic      mode_q;

   always_comb begin
      st_nx = st;
      if (mode_q != sync_mode) begin
         st_nx = ST_AWAKE;
      end else if (!sync_mode) begin
         if (chg)
            st_nx = ST_AWAKE;
         else if (stable)
            st_nx = ST_SLEEP;
      end else begin
         if (burst_start)
            st_nx = ST_AWAKE;
         else if (late || slow)
            st_nx = ST_SLEEP;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_AWAKE;
         mode_q <= 1'b0;
         dout   <= '0;
      end else begin
         st     <= st_nx;
         mode_q <= sync_mode;
         if (st == ST_AWAKE)
            dout <= din;
      end
   end

   assign sleep = (st == ST_SLEEP);

   // R4: data stays frozen across consecutive sleeping cycles
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SLEEP) |=> ((st == ST_AWAKE) || $stable(dout)));

   // R3: an address change in asynchronous mode wakes the block
   p_async_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_mode && chg) |=> (st == ST_AWAKE));

   // R7: asleep in synchronous mode, nothing but a burst start wakes
   p_sync_stay_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_SLEEP) && sync_mode && mode_q && !burst_start) |=> (st == ST_SLEEP));

   // R8: burst activity cannot put the asynchronous path to sleep
   p_async_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_AWAKE) && !sync_mode && !mode_q && !stable) |=> (st == ST_AWAKE));

   // R9: a mode change forces the awake state
   p_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_mode != mode_q) |=> (st == ST_AWAKE));

endmodule

// File: rtl/autosleep_det.sv
module autosleep_det
   import asd_pkg::*;
#(
   parameter int AW           = 16,
   parameter int DW           = 16,
   parameter int REF_PS       = 8000,
   parameter int ACC_NS       = 80,
   parameter int MARGIN_NS    = 60,
   parameter int MIN_FREQ_KHZ = 5000,
   parameter bit EDGE_RISE    = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sync_mode,
   input  logic [AW-1:0] addr,
   input  logic          bclk,
   input  logic          burst_start,
   input  logic [DW-1:0] din,
   output logic          sleep,
   output logic          latch_en,
   output logic [DW-1:0] dout
);
   localparam longint SLOW_PS   = 64'd1_000_000_000 / longint'(MIN_FREQ_KHZ);
   localparam int     STAB_CYC  = ceil_div(longint'(ACC_NS + MARGIN_NS) * 1000, REF_PS);
   localparam int     LATE_CYC  = ceil_div(longint'(ACC_NS) * 1000, REF_PS);
   localparam int     SLOW_CYC  = ceil_div(SLOW_PS, REF_PS);

   generate
      if (AW < 1 || DW < 1) begin : g_bad_width
         $error("autosleep_det: AW and DW must be positive");
      end
      if (REF_PS < 1 || MIN_FREQ_KHZ < 1) begin : g_bad_clock
         $error("autosleep_det: REF_PS and MIN_FREQ_KHZ must be positive");
      end
      if (ACC_NS < 1 || MARGIN_NS < 0) begin : g_bad_time
         $error("autosleep_det: ACC_NS must be positive and MARGIN_NS non-negative");
      end
      if (SLOW_CYC < 2) begin : g_bad_slow
         $error("autosleep_det: slow-clock limit needs at least two reference cycles");
      end
   endgenerate

   logic chg, stable, late, slow;

   asd_addr_watch #(
      .AW  (AW),
      .THR (STAB_CYC)
   ) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr   (addr),
      .chg    (chg),
      .stable (stable)
   );

   asd_bclk_watch #(
      .LATE      (LATE_CYC),
      .SLOW      (SLOW_CYC),
      .EDGE_RISE (EDGE_RISE)
   ) u_bclk (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (sync_mode),
      .bclk        (bclk),
      .burst_start (burst_start),
      .late        (late),
      .slow        (slow)
   );

   asd_sleep_fsm #(
      .DW (DW)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .sync_mode   (sync_mode),
      .chg         (chg),
      .stable      (stable),
      .late        (late),
      .slow        (slow),
      .burst_start (burst_start),
      .din         (din),
      .sleep       (sleep),
      .dout        (dout)
   );

   assign latch_en = sleep;

   // R1: nothing is frozen right after reset
   p_reset_r1: assert property (@(posedge clk)
      !rst_n |=> (!sleep && !latch_en && (dout == '0)));

endmodule

// File: tb/sim_autosleep_det.sv
module sim_autosleep_det;
   localparam int AW   = 16;
   localparam int DW   = 16;
   // derived by hand from 8 ns reference, 80 ns access, 60 ns margin, 5 MHz
   localparam int STAB = 18;
   localparam int LATE = 10;
   localparam int SLOW = 25;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sync_mode = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          bclk = 1'b0;
   logic          burst_start = 1'b0;
   logic [DW-1:0] din = '0;
   logic          sleep, latch_en;
   logic [DW-1:0] dout;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   autosleep_det u0 (
      .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .addr(addr),
      .bclk(bclk), .burst_start(burst_start), .din(din),
      .sleep(sleep), .latch_en(latch_en), .dout(dout)
   );

   typedef struct {
      string         req;
      logic          exp_sleep;
      logic          chk_d;
      logic [DW-1:0] exp_d;
   } item_t;

   item_t sbq[$];
   event  ev_chk;

   task automatic expect_now(input string r, input logic s, input logic cd, input logic [DW-1:0] d);
      item_t it;
      it.req = r; it.exp_sleep = s; it.chk_d = cd; it.exp_d = d;
      sbq.push_back(it);
      ->ev_chk;
      #0;
   endtask

   initial begin
      forever begin
         @(ev_chk);
         while (sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            checks++;
            if (sleep !== it.exp_sleep || latch_en !== it.exp_sleep) begin
               errors++;
               $display("FAIL %s sleep=%b latch_en=%b expected %b", it.req, sleep, latch_en, it.exp_sleep);
            end else if (it.chk_d && dout !== it.exp_d) begin
               errors++;
               $display("FAIL %s dout=%h expected %h", it.req, dout, it.exp_d);
            end
         end
      end
   end

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_start();
      @(negedge clk) burst_start = 1'b1;
      @(negedge clk) burst_start = 1'b0;
   endtask

   // first bclk rise sampled k edges after the start edge
   task automatic burst_first(input int k);
      pulse_start();
      wait_n(k - 1);
      bclk = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      wait_n(4);
      expect_now("R1 reset", 1'b0, 1'b1, 16'h0000);
      rst_n = 1'b1;

      // R2: entry exactly STAB+1 edges after the change edge
      @(negedge clk) begin addr = 16'h1234; din = 16'hAAAA; end
      wait_n(STAB + 1);
      expect_now("R2 before threshold", 1'b0, 1'b1, 16'hAAAA);
      wait_n(1);
      expect_now("R2 entry", 1'b1, 1'b1, 16'hAAAA);

      // R4: data frozen while asleep
      din = 16'h5555;
      wait_n(3);
      expect_now("R4 hold async", 1'b1, 1'b1, 16'hAAAA);

      // R3: address change wakes at the next edge
      addr = 16'h0F0F;
      wait_n(1);
      expect_now("R3 wake", 1'b0, 1'b1, 16'hAAAA);
      wait_n(1);
      expect_now("R4 follow after wake", 1'b0, 1'b1, 16'h5555);

      // R3: restart of the count on a second change
      wait_n(8);
      addr = 16'h0F10;
      wait_n(STAB + 1);
      expect_now("R3 restart before", 1'b0, 1'b0, '0);
      wait_n(1);
      expect_now("R3 restart entry", 1'b1, 1'b0, '0);

      // R8: burst activity ignored in asynchronous mode
      addr = 16'h2222;
      wait_n(1);
      pulse_start();
      wait_n(LATE + 2);
      bclk = 1'b1;
      @(negedge clk) bclk = 1'b0;
      wait_n(1);
      expect_now("R8 async ignores burst", 1'b0, 1'b0, '0);
      wait_n(STAB);
      expect_now("R8 async asleep again", 1'b1, 1'b0, '0);

      // R9: switching mode wakes
      sync_mode = 1'b1;
      wait_n(1);
      expect_now("R9 mode change", 1'b0, 1'b0, '0);
      din = 16'h1111;

      // R5: boundary, k-1 = LATE-1 stays awake
      burst_first(LATE);
      expect_now("R5 on-time edge", 1'b0, 1'b1, 16'h1111);
      bclk = 1'b0;
      // R5: k-1 = LATE sleeps
      burst_first(LATE + 1);
      expect_now("R5 late edge", 1'b1, 1'b1, 16'h1111);
      bclk = 1'b0;

      // R4 in synchronous mode, R7: address ignored
      din = 16'h7777;
      addr = 16'h3333;
      wait_n(3);
      expect_now("R7 address no wake", 1'b1, 1'b1, 16'h1111);

      // R7: burst start wakes
      pulse_start();
      expect_now("R7 burst wake", 1'b0, 1'b1, 16'h1111);
      wait_n(1);
      expect_now("R7 data follows", 1'b0, 1'b1, 16'h7777);

      // R6: period exactly SLOW stays awake
      burst_first(2);
      expect_now("R6 first edge", 1'b0, 1'b0, '0);
      bclk = 1'b0;
      wait_n(SLOW - 1);
      bclk = 1'b1;
      expect_now("R6 period SLOW pre", 1'b0, 1'b0, '0);
      @(negedge clk) bclk = 1'b0;
      expect_now("R6 period SLOW edge", 1'b0, 1'b0, '0);
      // R6: no edge for SLOW edges sleeps
      wait_n(SLOW - 1);
      expect_now("R6 slow before", 1'b0, 1'b0, '0);
      wait_n(1);
      expect_now("R6 slow entry", 1'b1, 1'b0, '0);

      wait_n(2);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule